// File: doc/BRIEF.md
# Receive DMA Control Sequencer

This block sequences a descriptor-driven receive DMA engine. After a start command it reads the next descriptor slot of a ring through a request/response port with no wait states. If the host has handed the slot to the engine, it waits for a recognized frame from the receive FIFO. It then streams the frame's beats to host memory through a write port with a ready signal. When a timestamp is enabled, it stores one in a separate step. Finally it closes the descriptor by presenting a status word, and moves on to the next slot.

If the next slot still belongs to the host, the engine suspends. It resumes on a poll demand, or by itself when the next recognized frame arrives. Stop commands are honoured in every state. A 3-bit process code shows where the engine is. One-cycle event pulses report:
- a completed frame,
- an early receive (first buffer filled),
- an unavailable buffer,
- a FIFO overflow,
- a frame-length watchdog timeout,
- a stopped process.

Top module: `rxdma_seq`

## Requirements
- R1: `state_code` uses 0 for Stopped, 1 for fetching a descriptor, 3 for waiting for a frame, 4 for Suspended, 5 for closing a descriptor, 6 for writing a timestamp and 7 for moving frame data; value 2 never appears. Reset leaves the code at 0 with all events low.
- R2: While not Stopped, a `cmd_stop` pulse moves the engine to Stopped on the next edge and pulses `ev_stopped` once. A stop while already Stopped raises no event. Stop wins over any other transition. `cmd_start` leaves Stopped for descriptor fetch, and the ring index is kept.
- R3: A fetched descriptor with `dsc_rsp_own`=0 (host-owned) sends the engine to Suspended. `ev_unavail` pulses only if the previously fetched descriptor was engine-owned; the first fetch after reset counts as having an engine-owned predecessor.
- R4: In Suspended, either `cmd_poll` or `fifo_frame_rdy` returns the engine to descriptor fetch of the same slot.
- R5: `ev_early` pulses once per frame, after the beat that brings the frame's byte count to at least BUF_BYTES (default 64).
- R6: After the status handshake (`cls_valid`&`cls_ready`), `ev_rx_done` pulses in the following cycle unless the descriptor's `dsc_rsp_noirq` flag was 1. The engine then fetches the next descriptor; it does not stop.
- R7: The watchdog fires once per frame, on the beat where the byte count first exceeds 2048 (10240 with `cfg_jumbo`=1). It pulses `ev_wdt` and sets status bit 14.
- R8: `fifo_ovf` during data transfer pulses `ev_ovf`. The frame is still closed, with status bit 15 set.
- R9: With `cfg_ts_en`=1, the engine holds code 6 with `ts_valid` high between the last beat and the close, until `ts_ready`. With `cfg_ts_en`=0 it goes straight to close.
- R10: `dsc_addr` advances by one slot after each close and wraps from RING_SIZE-1 (default 7) to 0.
- R11: Status bits [13:0] hold the frame length in bytes, counting BEAT_BYTES (default 4) per accepted beat and saturating at 16383.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Stop pulse |
| cmd_poll | input | 1 | Receive poll demand pulse |
| cfg_jumbo | input | 1 | Selects the long watchdog limit |
| cfg_ts_en | input | 1 | Enables the timestamp step |
| dsc_req | output | 1 | Descriptor read request |
| dsc_addr | output | IDX_W | Ring slot being read |
| dsc_rsp_valid | input | 1 | Descriptor response valid |
| dsc_rsp_own | input | 1 | 1 = engine owns the slot |
| dsc_rsp_noirq | input | 1 | 1 = suppress completion event |
| fifo_frame_rdy | input | 1 | A recognized frame is waiting |
| fifo_valid | input | 1 | FIFO beat valid |
| fifo_last | input | 1 | Beat is the frame's last |
| fifo_ovf | input | 1 | FIFO overflow during this frame |
| fifo_ready | output | 1 | Beat accepted |
| wr_valid | output | 1 | Host write valid |
| wr_ready | input | 1 | Host write ready |
| ts_valid | output | 1 | Timestamp write request |
| ts_ready | input | 1 | Timestamp write done |
| cls_valid | output | 1 | Status write request |
| cls_status | output | 16 | {overflow, watchdog, length[13:0]} |
| cls_ready | input | 1 | Status write done |
| state_code | output | 3 | Process state code |
| ev_rx_done | output | 1 | Frame complete pulse |
| ev_early | output | 1 | Early receive pulse |
| ev_unavail | output | 1 | Buffer unavailable pulse |
| ev_ovf | output | 1 | Overflow pulse |
| ev_wdt | output | 1 | Watchdog timeout pulse |
| ev_stopped | output | 1 | Process stopped pulse |

## Verification
The hardest situation to reach is the qualified buffer-unavailable event. A host-owned slot must be met twice in a row, and then again right after an engine-owned slot that carried a real frame. The stimulus first starts on a host-owned ring so that a poll demand refetches the same slot. It then runs frames through six slots and leaves slot 6 host-owned, so the suspend comes straight after a completed close. The bench then resumes that suspend through frame arrival instead of a poll. The watchdog needs frames of more than 512 beats, sent with and without the long limit.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int LEN_W = 14;

  typedef enum logic [2:0] {
    ST_STOP   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_WAIT   = 3'd3,
    ST_SUSP   = 3'd4,
    ST_CLOSE  = 3'd5,
    ST_TSTAMP = 3'd6,
    ST_XFER   = 3'd7
  } rx_state_e;

  // saturating length add
  function automatic logic [LEN_W-1:0] len_add(input logic [LEN_W-1:0] a,
                                               input logic [LEN_W-1:0] b);
    logic [LEN_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[LEN_W] ? '1 : s[LEN_W-1:0];
  endfunction

  function automatic logic [LEN_W-1:0] wdt_limit(input logic jumbo,
                                                 input logic [LEN_W-1:0] std_lim,
                                                 input logic [LEN_W-1:0] jum_lim);
    return jumbo ? jum_lim : std_lim;
  endfunction
endpackage

// File: rtl/rxdma_len_watch.sv
module rxdma_len_watch
  import rxdma_pkg::*;
#(
  parameter int BEAT_BYTES  = 4,
  parameter int BUF_BYTES   = 64,
  parameter int STD_LIMIT   = 2048,
  parameter int JUMBO_LIMIT = 10240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             beat,
  input  logic             jumbo,
  output logic             early_hit,
  output logic             wdt_hit,
  output logic [LEN_W-1:0] len
);
  localparam logic [LEN_W-1:0] BEAT_L = LEN_W'(BEAT_BYTES);
  localparam logic [LEN_W-1:0] BUF_L  = LEN_W'(BUF_BYTES);
  localparam logic [LEN_W-1:0] STD_L  = LEN_W'(STD_LIMIT);
  localparam logic [LEN_W-1:0] JUM_L  = LEN_W'(JUMBO_LIMIT);
  localparam logic [LEN_W-1:0] MAX_L  = '1;

  logic             early_done, wdt_done;
  logic [LEN_W-1:0] len_nxt, limit;

  assign len_nxt   = len_add(len, BEAT_L);
  assign limit     = wdt_limit(jumbo, STD_L, JUM_L);
  assign early_hit = beat && !early_done && (len_nxt >= BUF_L);
  assign wdt_hit   = beat && !wdt_done && (len_nxt > limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len <= '0; early_done <= 1'b0; wdt_done <= 1'b0;
    end else if (clr) begin
      len <= '0; early_done <= 1'b0; wdt_done <= 1'b0;
    end else if (beat) begin
      len <= len_nxt;
      if (early_hit) early_done <= 1'b1;
      if (wdt_hit)   wdt_done   <= 1'b1;
    end
  end

  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !clr && len <= MAX_L - BEAT_L) |=> len == $past(len) + BEAT_L); // R11
  AST_LEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> len == '0); // R11
endmodule

// File: rtl/rxdma_ring_ptr.sv
module rxdma_ring_ptr #(
  parameter  int RING_SIZE = 8,
  localparam int IDX_W     = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             seen,
  input  logic             seen_own,
  output logic [IDX_W-1:0] idx,
  output logic             prev_own
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_SIZE - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      prev_own <= 1'b1;
    end else begin
      if (advance) idx <= (idx == LAST) ? '0 : idx + 1'b1;
      if (seen)    prev_own <= seen_own;
    end
  end

  AST_RING_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && idx == LAST) |=> idx == '0); // R10
  AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(idx)); // R10
endmodule

// File: rtl/rxdma_seq.sv
module rxdma_seq
  import rxdma_pkg::*;
#(
  parameter  int RING_SIZE   = 8,
  parameter  int BEAT_BYTES  = 4,
  parameter  int BUF_BYTES   = 64,
  parameter  int STD_LIMIT   = 2048,
  parameter  int JUMBO_LIMIT = 10240,
  localparam int IDX_W       = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_poll,
  input  logic             cfg_jumbo,
  input  logic             cfg_ts_en,
  output logic             dsc_req,
  output logic [IDX_W-1:0] dsc_addr,
  input  logic             dsc_rsp_valid,
  input  logic             dsc_rsp_own,
  input  logic             dsc_rsp_noirq,
  input  logic             fifo_frame_rdy,
  input  logic             fifo_valid,
  input  logic             fifo_last,
  input  logic             fifo_ovf,
  output logic             fifo_ready,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic             ts_valid,
  input  logic             ts_ready,
  output logic             cls_valid,
  output logic [15:0]      cls_status,
  input  logic             cls_ready,
  output logic [2:0]       state_code,
  output logic             ev_rx_done,
  output logic             ev_early,
  output logic             ev_unavail,
  output logic             ev_ovf,
  output logic             ev_wdt,
  output logic             ev_stopped
);
  rx_state_e        state;
  logic             noirq_q, ovf_flag, wdt_flag;
  logic [LEN_W-1:0] len;

  // named internal events
  logic beat, frame_start, desc_seen, desc_advance, early_hit, wdt_hit, prev_own;

  assign beat         = (state == ST_XFER) && fifo_valid && wr_ready;
  assign frame_start  = (state == ST_WAIT) && fifo_frame_rdy && !cmd_stop;
  assign desc_seen    = (state == ST_FETCH) && dsc_rsp_valid && !cmd_stop;
  assign desc_advance = (state == ST_CLOSE) && cls_ready && !cmd_stop;

  assign state_code = state;
  assign dsc_req    = (state == ST_FETCH);
  assign fifo_ready = (state == ST_XFER) && wr_ready;
  assign wr_valid   = (state == ST_XFER) && fifo_valid;
  assign ts_valid   = (state == ST_TSTAMP);
  assign cls_valid  = (state == ST_CLOSE);
  assign cls_status = {ovf_flag, wdt_flag, len};

  rxdma_len_watch #(
    .BEAT_BYTES(BEAT_BYTES), .BUF_BYTES(BUF_BYTES),
    .STD_LIMIT(STD_LIMIT), .JUMBO_LIMIT(JUMBO_LIMIT)
  ) u_len (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .beat(beat), .jumbo(cfg_jumbo),
    .early_hit(early_hit), .wdt_hit(wdt_hit), .len(len)
  );

  rxdma_ring_ptr #(.RING_SIZE(RING_SIZE)) u_ring (
    .clk(clk), .rst_n(rst_n), .advance(desc_advance), .seen(desc_seen),
    .seen_own(dsc_rsp_own), .idx(dsc_addr), .prev_own(prev_own)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_STOP;
      noirq_q <= 1'b0; ovf_flag <= 1'b0; wdt_flag <= 1'b0;
      ev_rx_done <= 1'b0; ev_early <= 1'b0; ev_unavail <= 1'b0;
      ev_ovf <= 1'b0; ev_wdt <= 1'b0; ev_stopped <= 1'b0;
    end else begin
      ev_rx_done <= 1'b0; ev_early <= 1'b0; ev_unavail <= 1'b0;
      ev_ovf <= 1'b0; ev_wdt <= 1'b0; ev_stopped <= 1'b0;
      if (cmd_stop && state != ST_STOP) begin
        state      <= ST_STOP;
        ev_stopped <= 1'b1;
      end else begin
        case (state)
          ST_STOP:  if (cmd_start) state <= ST_FETCH;
          ST_FETCH: if (dsc_rsp_valid) begin
            if (dsc_rsp_own) begin
              noirq_q <= dsc_rsp_noirq;
              state   <= ST_WAIT;
            end else begin
              ev_unavail <= prev_own;
              state      <= ST_SUSP;
            end
          end
          ST_WAIT: if (fifo_frame_rdy) begin
            ovf_flag <= 1'b0;
            wdt_flag <= 1'b0;
            state    <= ST_XFER;
          end
          ST_XFER: begin
            ev_early <= early_hit;
            ev_wdt   <= wdt_hit;
            if (wdt_hit) wdt_flag <= 1'b1;
            if (fifo_ovf) begin
              ev_ovf   <= 1'b1;
              ovf_flag <= 1'b1;
            end
            if (beat && fifo_last) state <= cfg_ts_en ? ST_TSTAMP : ST_CLOSE;
          end
          ST_TSTAMP: if (ts_ready) state <= ST_CLOSE;
          ST_CLOSE: if (cls_ready) begin
            ev_rx_done <= !noirq_q;
            state      <= ST_FETCH;
          end
          ST_SUSP: if (cmd_poll || fifo_frame_rdy) state <= ST_FETCH;
          default: state <= ST_STOP;
        endcase
      end
    end
  end

  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && state_code != 3'd0) |=> (state_code == 3'd0 && ev_stopped)); // R2
  AST_UNAVAIL_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unavail |-> state_code == 3'd4); // R3
  AST_SUSP_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd4 && (cmd_poll || fifo_frame_rdy) && !cmd_stop) |=> state_code == 3'd1); // R4
  AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |-> $past(cls_valid && cls_ready)); // R6
  AST_TS_THEN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_valid && ts_ready && !cmd_stop) |=> cls_valid); // R9
  AST_WDT_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wdt |-> cls_status[14]); // R7
endmodule

// File: tb/tb_rxdma_seq.sv
module tb_rxdma_seq;
  localparam int CLK_PERIOD = 10;

  typedef enum int {K_STOP, K_UNAV, K_OVF, K_EARLY, K_WDT, K_CLOSE, K_DONE} kind_e;
  typedef struct { kind_e kind; int val; string req; } item_t;

  logic clk = 0, rst_n = 0;
  logic cmd_start = 0, cmd_stop = 0, cmd_poll = 0, cfg_jumbo = 0, cfg_ts_en = 0;
  logic dsc_req, dsc_rsp_valid, dsc_rsp_own, dsc_rsp_noirq;
  logic [2:0] dsc_addr;
  logic fifo_frame_rdy = 0, fifo_valid = 0, fifo_last = 0, fifo_ovf = 0, fifo_ready;
  logic wr_valid, wr_ready = 1, ts_valid, ts_ready = 1, cls_valid, cls_ready = 1;
  logic [15:0] cls_status;
  logic [2:0] state_code;
  logic ev_rx_done, ev_early, ev_unavail, ev_ovf, ev_wdt, ev_stopped;
  logic own_mem [8];
  logic noirq_mem [8];

  int tests = 0, fails = 0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign dsc_rsp_valid = dsc_req;
  assign dsc_rsp_own   = own_mem[dsc_addr];
  assign dsc_rsp_noirq = noirq_mem[dsc_addr];

  rxdma_seq dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input kind_e k, input int v, input string req);
    item_t it;
    it.kind = k; it.val = v; it.req = req;
    sb.push_back(it);
  endtask

  function automatic string kind_req(input kind_e k);
    case (k)
      K_STOP: return "R2"; K_UNAV: return "R3"; K_OVF: return "R8";
      K_EARLY: return "R5"; K_WDT: return "R7"; K_CLOSE: return "R11";
      default: return "R6";
    endcase
  endfunction

  task automatic observe(input kind_e k, input int v);
    item_t it;
    if (sb.size() == 0) begin
      check(0, {kind_req(k), " unexpected event"}, int'(k), -1);
    end else begin
      it = sb.pop_front();
      check(it.kind == k && it.val == v, it.req, int'(k) * 100000 + v,
            int'(it.kind) * 100000 + it.val);
    end
  endtask

  // monitor: pops expected items as the design produces events
  always @(negedge clk) if (rst_n) begin
    if (ev_stopped) observe(K_STOP, 0);
    if (ev_unavail) observe(K_UNAV, 0);
    if (ev_ovf)     observe(K_OVF, 0);
    if (ev_early)   observe(K_EARLY, 0);
    if (ev_wdt)     observe(K_WDT, 0);
    if (cls_valid && cls_ready) observe(K_CLOSE, int'(cls_status));
    if (ev_rx_done) observe(K_DONE, 0);
  end

  // driver-side model: expected events of one frame, from the requirements
  task automatic expect_frame(input int n, input int ovf_beat, input bit noirq, input bit jumbo);
    int limit = jumbo ? 10240 : 2048;
    bit e_done = 0, w_done = 0, ovf = 0, wdt = 0;
    int bytes = 0;
    for (int b = 1; b <= n; b++) begin
      bytes = (b * 4 > 16383) ? 16383 : b * 4;
      if (b == ovf_beat) begin push(K_OVF, 0, "R8"); ovf = 1; end
      if (!e_done && bytes >= 64) begin push(K_EARLY, 0, "R5"); e_done = 1; end
      if (!w_done && bytes > limit) begin push(K_WDT, 0, "R7"); w_done = 1; wdt = 1; end
    end
    push(K_CLOSE, (int'(ovf) << 15) | (int'(wdt) << 14) | bytes, "R11");
    if (!noirq) push(K_DONE, 0, "R6");
  endtask

  task automatic wait_code(input logic [2:0] code, input string req);
    int n = 0;
    while (state_code !== code && n < 100) begin @(negedge clk); n++; end
    check(state_code === code, req, int'(state_code), int'(code));
  endtask

  task automatic send_frame(input int n, input int ovf_beat);
    fifo_frame_rdy = 1;
    wait_code(3'd7, "R1 transfer code");
    fifo_frame_rdy = 0;
    for (int b = 1; b <= n; b++) begin
      fifo_valid = 1; fifo_last = (b == n); fifo_ovf = (b == ovf_beat);
      @(negedge clk);
    end
    fifo_valid = 0; fifo_last = 0; fifo_ovf = 0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1; @(negedge clk); sig = 0;
  endtask

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin own_mem[i] = 0; noirq_mem[i] = 0; end
    repeat (3) @(negedge clk);
    check(state_code == 3'd0 && !ev_stopped && !ev_unavail && !ev_rx_done,
          "R1 reset state", int'(state_code), 0);
    rst_n = 1;
    @(negedge clk);

    // R3: host-owned first slot suspends with event
    push(K_UNAV, 0, "R3");
    pulse(cmd_start);
    wait_code(3'd4, "R3 suspend on host-owned");
    check(dsc_addr == 3'd0, "R10 first slot", int'(dsc_addr), 0);
    // R3: refetch of the same host-owned slot: no second event
    pulse(cmd_poll);
    repeat (3) @(negedge clk);
    check(state_code == 3'd4, "R3 re-suspend silent", int'(state_code), 4);

    for (int i = 0; i < 8; i++) own_mem[i] = 1;
    own_mem[6] = 0;
    noirq_mem[1] = 1;
    pulse(cmd_poll);
    wait_code(3'd3, "R4 poll resume to wait");

    expect_frame(20, 0, 0, 0);            // R5 early, R6 done
    send_frame(20, 0);
    expect_frame(10, 0, 1, 0);            // R6 suppressed completion
    send_frame(10, 0);

    cfg_ts_en = 1; ts_ready = 0;          // R9 timestamp step
    expect_frame(4, 0, 0, 0);
    send_frame(4, 0);
    check(state_code == 3'd6 && ts_valid, "R9 timestamp state", int'(state_code), 6);
    repeat (2) @(negedge clk);
    check(state_code == 3'd6, "R9 timestamp holds", int'(state_code), 6);
    ts_ready = 1;
    @(negedge clk);
    cfg_ts_en = 0;

    expect_frame(520, 0, 0, 0);           // R7 standard limit
    send_frame(520, 0);
    cfg_jumbo = 1;
    expect_frame(520, 0, 0, 1);           // R7 jumbo limit: no timeout
    send_frame(520, 0);
    cfg_jumbo = 0;

    expect_frame(8, 3, 0, 0);             // R8 overflow
    push(K_UNAV, 0, "R3");                // slot 6 host-owned after engine-owned slot
    send_frame(8, 0 + 3);
    wait_code(3'd4, "R3 suspend after owned slot");
    check(dsc_addr == 3'd6, "R10 slot index", int'(dsc_addr), 6);

    own_mem[6] = 1;                       // R4 resume on frame arrival
    expect_frame(4, 0, 0, 0);
    send_frame(4, 0);
    expect_frame(4, 0, 0, 0);
    send_frame(4, 0);
    wait_code(3'd3, "R10 wait after wrap");
    check(dsc_addr == 3'd0, "R10 wrap to slot 0", int'(dsc_addr), 0);

    push(K_STOP, 0, "R2");
    pulse(cmd_stop);
    check(state_code == 3'd0, "R2 stopped", int'(state_code), 0);
    pulse(cmd_stop);                      // no event while stopped
    repeat (3) @(negedge clk);
    check(state_code == 3'd0, "R2 stays stopped", int'(state_code), 0);
    pulse(cmd_start);
    wait_code(3'd3, "R2 restart keeps index");
    check(dsc_addr == 3'd0, "R2 index kept", int'(dsc_addr), 0);

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R6 all expected events seen", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule